// File: doc/BRIEF.md
# Event Timer Shared Register Block

This block is the common core of a multi-channel event timer. It owns the 64-bit main up-counter and the registers that every comparator channel shares: a read-only capability word, a two-bit configuration word (run and legacy replacement), and a per-channel interrupt-pending word whose bits are cleared by writing ones. It decodes a 1 KiB register window. Accesses that land on a channel's 32-byte slot are passed to that channel through a one-hot select, and the channel's read data comes back through the same response path.

The counter advances by one on each cycle in which the tick strobe is high and the run bit is set. The channels report expiries to this block. It keeps the level-type pending bits, routes every channel onto one of 32 interrupt lines, and registers the result. In legacy replacement mode, channel 0 takes line 0 and channel 1 takes line 8, whatever their own route fields hold. The external PIT and RTC interrupt inputs, which otherwise pass through to those two lines, are shut off in that mode, and the PIT-enable output drops.

Top module: `evt_timer_global`

## Requirements
- R1: After reset the configuration word, the counter and the pending word read zero, PIT-enable is 1 and all interrupt lines are low.
- R2: The capability word is read-only. Its fields are: bits 7:0 = 1; bits 12:8 = channel count minus one; bit 13 = 1; bit 14 = 0; bit 15 = 1; bits 31:16 = the vendor parameter (default 0x5A17); bits 63:32 = the tick period in femtoseconds (default 10,000,000). Writes to it are ignored.
- R3: In the configuration word at offset 0x010, only bit 0 (run) and bit 1 (legacy replacement) can be written. All other bits read zero, and a write to its upper half changes nothing.
- R4: The counter at offset 0x0F0 increments by one on each clock edge where run is 1 and the tick strobe is high. While run is 0 it holds its value, and reads return the held value.
- R5: A counter write loads the addressed half (32-bit access) or the whole word (64-bit access), even while running. A write takes priority over a tick on the same edge.
- R6: The pending word at offset 0x020 sets bit n when channel n reports an expiry while configured level-type. Writing 1 to a bit clears it and writing 0 has no effect. A set and a clear of the same bit on the same edge leave the bit set. A write to the upper half clears nothing.
- R7: Address bit 2 selects the upper 32-bit half of a 64-bit register, which is returned in bits 31:0. A 32-bit read returns zeros in bits 63:32. A read's data appears on the response one clock after the request edge.
- R8: Channel n is mapped at 0x100 + n*0x20 for n below the channel count. An access to it raises only select bit n, and the read returns the channel's read data unchanged. An offset that maps to no register or channel reads zero.
- R9: A channel with its interrupt enabled drives its line while run is 1. A level-type channel drives it for as long as its pending bit is set. An edge-type channel drives it for exactly one cycle. Either way the line changes one clock after the event edge.
- R10: In legacy mode channel 0 drives line 0 and channel 1 drives line 8, and their route fields are ignored. Channels 2 and above keep their route fields.
- R11: Outside legacy mode the PIT input is ORed onto line 0 and the RTC input onto line 8, one clock later. In legacy mode both inputs are ignored and PIT-enable is 0. After legacy mode is left, line 8 again follows the RTC input.
- R12: Clearing run drops every channel-driven line on the next clock but keeps the pending bits. Setting run again re-asserts the lines of pending, enabled level-type channels one clock after the configuration write.
- R13: The channel-count parameter is clamped to the range 3 to 32, and that clamped value sets the port widths and capability bits 12:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance strobe |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| req_addr | input | 10 | Byte offset in the window |
| req_wdata | input | 64 | Write data (bits 31:0 for 32-bit access) |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 64 | Read data |
| tmr_sel | output | NT | One-hot channel slot select |
| tmr_rdata | input | 64 | Read data of the selected channel |
| tmr_hit | input | NT | Per-channel expiry strobe |
| tmr_level | input | NT | Per-channel level-type flag |
| tmr_int_en | input | NT | Per-channel interrupt enable |
| tmr_route | input | 5*NT | Per-channel line number, channel 0 in bits 4:0 |
| pit_in | input | 1 | External PIT interrupt level |
| rtc_in | input | 1 | External RTC interrupt level |
| pit_en | output | 1 | PIT enable, low in legacy mode |
| irq_line | output | 32 | Interrupt lines |

## Verification
Register effects land on the request edge, so the bench reads them back with a later request. Its response is sampled at the falling edge that follows the request edge. Interrupt lines go through one extra register. After a pulse, a configuration write or a pending-word write, the bench therefore first confirms at the falling edge right after the event that the line has not yet moved, then checks the new value one falling edge later. Counter checks count the exact edges on which run and tick overlap, including an edge where a load and a tick collide, so every expected value is a plain sum.

// File: rtl/evt_pkg.sv
// Shared constants, decode types and the channel-count clamp for the
// event timer shared register block.
package evt_pkg;
    localparam int TMR_MIN = 3;
    localparam int TMR_MAX = 32;
    localparam int ADDR_W  = 10;
    localparam int ROUTE_W = 5;
    localparam int CFG_W   = 2;

    localparam logic [ADDR_W-1:0] OFS_CAP      = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_CFG      = 10'h010;
    localparam logic [ADDR_W-1:0] OFS_STS      = 10'h020;
    localparam logic [ADDR_W-1:0] OFS_CNT      = 10'h0F0;
    localparam logic [ADDR_W-1:0] OFS_TMR_BASE = 10'h100;

    // Fixed lines taken over in legacy replacement mode.
    localparam int LINE_PIT = 0;
    localparam int LINE_RTC = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP,
        SEL_CFG,
        SEL_STS,
        SEL_CNT,
        SEL_TMR
    } reg_sel_e;

    // Clamp the requested channel count into the supported range.
    function automatic int nt_of(input int n);
        if (n < TMR_MIN) return TMR_MIN;
        if (n > TMR_MAX) return TMR_MAX;
        return n;
    endfunction
endpackage

// File: rtl/evt_regdec.sv
// Address decoder for the 1 KiB register window.
// Produces the register class, the one-hot channel slot and the half select.
// Assumes naturally aligned accesses; address bits 1:0 are ignored.
module evt_regdec
    import evt_pkg::*;
#(
    parameter int NT = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [NT-1:0]     tsel,
    output logic              upper
);
    localparam int TIDX_W = ADDR_W - 5;
    localparam logic [TIDX_W-1:0] TIDX_BASE = TIDX_W'(OFS_TMR_BASE >> 5);

    logic [ADDR_W-1:0] word;
    logic              in_tmr;
    logic [TIDX_W-1:0] tidx;

    assign upper  = addr[2];
    assign word   = {addr[ADDR_W-1:3], 3'b000};
    assign in_tmr = (word >= OFS_TMR_BASE);
    assign tidx   = addr[ADDR_W-1:5] - TIDX_BASE;

    // One select line per channel slot.
    for (genvar g = 0; g < NT; g++) begin : g_slot
        assign tsel[g] = in_tmr && (tidx == TIDX_W'(g));
    end

    // Classify the access.
    always_comb begin
        sel = SEL_NONE;
        if (in_tmr) begin
            if (|tsel) sel = SEL_TMR;
        end else begin
            case (word)
                OFS_CAP: sel = SEL_CAP;
                OFS_CFG: sel = SEL_CFG;
                OFS_STS: sel = SEL_STS;
                OFS_CNT: sel = SEL_CNT;
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/evt_main_counter.sv
// Main up-counter. Loads per 32-bit half take priority over a tick.
// Assumes the write data is already aligned to the half it targets.
module evt_main_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count
);
    localparam int HW = W / 2;

    logic [W-1:0] cnt_q;

    // Load, advance or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt_q[HW-1:0] <= wdata[HW-1:0];
            if (wr_hi) cnt_q[W-1:HW] <= wdata[W-1:HW];
        end else if (run && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(count)); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !wr_lo && !wr_hi) |=> (count == $past(count) + 1'b1)); // R4
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (count[HW-1:0] == $past(wdata[HW-1:0]))); // R5
endmodule

// File: rtl/evt_int_status.sv
// Interrupt-pending word: set by level-type expiries, cleared by write-one.
// A set on the same edge as a clear wins.
module evt_int_status #(
    parameter int NT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] set_vec,
    input  logic [NT-1:0] clr_vec,
    output logic [NT-1:0] status
);
    logic [NT-1:0] sts_q;

    // Apply clears, then sets.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr_vec) | set_vec;
    end

    assign status = sts_q;

    AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((status & $past(clr_vec & ~set_vec)) == '0)); // R6
    AST_STS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec == '0 && set_vec == '0) |=> $stable(status)); // R6
    AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec))); // R6
endmodule

// File: rtl/evt_irq_router.sv
// Maps channel interrupt requests and the PIT/RTC pass-through onto the
// interrupt lines, applying legacy replacement. The output is registered.
// Assumes hit is a one-cycle strobe and status is already registered.
module evt_irq_router
    import evt_pkg::*;
#(
    parameter int NT = 3,
    parameter int RW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              legacy,
    input  logic [NT-1:0]     int_en,
    input  logic [NT-1:0]     level,
    input  logic [NT-1:0]     hit,
    input  logic [NT*RW-1:0]  route,
    input  logic [NT-1:0]     status,
    input  logic              pit_in,
    input  logic              rtc_in,
    output logic [(1<<RW)-1:0] irq
);
    localparam int NL = 1 << RW;

    logic [NT-1:0] hit_q;
    logic [NT-1:0] drv;
    logic [NL-1:0] nxt;
    logic [NL-1:0] irq_q;

    // Delay edge strobes so both trigger types meet the same register.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= '0;
        else        hit_q <= hit;
    end

    // Per-channel drive request.
    always_comb drv = {NT{en}} & int_en & ((level & status) | (~level & hit_q));

    // Fold every channel onto its effective line and add the pass-through.
    always_comb begin
        nxt = '0;
        for (int t = 0; t < NT; t++) begin : route_loop
            logic [RW-1:0] dst;
            dst = route[t*RW +: RW];
            if (legacy && t == 0)      dst = RW'(LINE_PIT);
            else if (legacy && t == 1) dst = RW'(LINE_RTC);
            nxt[dst] = nxt[dst] | drv[t];
        end
        if (!legacy) begin
            nxt[LINE_PIT] = nxt[LINE_PIT] | pit_in;
            nxt[LINE_RTC] = nxt[LINE_RTC] | rtc_in;
        end
    end

    // Register the lines.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= nxt;
    end

    assign irq = irq_q;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !pit_in && !rtc_in) |=> (irq == '0)); // R12
    AST_LEG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy && drv == '0) |=> (irq == '0)); // R11
    AST_PIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy && pit_in) |=> irq[LINE_PIT]); // R11
endmodule

// File: rtl/evt_timer_global.sv
// Shared register block of a multi-channel event timer: capability,
// configuration, pending word and main counter, window decode, interrupt
// routing with legacy replacement. Reads answer one clock after the request.
// Assumes channel slots return already-aligned read data on tmr_rdata.
module evt_timer_global
    import evt_pkg::*;
#(
    parameter int          NUM_TIMERS = 3,
    parameter logic [15:0] VENDOR_ID  = 16'h5A17,
    parameter logic [31:0] TICK_FS    = 32'd10_000_000
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   tick_en,
    input  logic                                   req_valid,
    input  logic                                   req_write,
    input  logic                                   req_wide,
    input  logic [9:0]                             req_addr,
    input  logic [63:0]                            req_wdata,
    output logic                                   rsp_valid,
    output logic [63:0]                            rsp_data,
    output logic [evt_pkg::nt_of(NUM_TIMERS)-1:0]  tmr_sel,
    input  logic [63:0]                            tmr_rdata,
    input  logic [evt_pkg::nt_of(NUM_TIMERS)-1:0]  tmr_hit,
    input  logic [evt_pkg::nt_of(NUM_TIMERS)-1:0]  tmr_level,
    input  logic [evt_pkg::nt_of(NUM_TIMERS)-1:0]  tmr_int_en,
    input  logic [evt_pkg::nt_of(NUM_TIMERS)*5-1:0] tmr_route,
    input  logic                                   pit_in,
    input  logic                                   rtc_in,
    output logic                                   pit_en,
    output logic [31:0]                            irq_line
);
    localparam int NT = nt_of(NUM_TIMERS);
    localparam logic [63:0] CAP_WORD =
        {TICK_FS, VENDOR_ID, 1'b1, 1'b0, 1'b1, 5'(NT - 1), 8'h01};

    reg_sel_e        sel;
    logic            upper;
    logic [NT-1:0]   tsel;
    logic            wr_ok;
    logic            cfg_wr;
    logic            cnt_wr_lo;
    logic            cnt_wr_hi;
    logic [63:0]     wd_al;
    logic [NT-1:0]   sts_clr;
    logic [NT-1:0]   sts_set;
    logic [NT-1:0]   status;
    logic [CFG_W-1:0] cfg_q;
    logic [63:0]     count;
    logic [63:0]     rd_word;
    logic [63:0]     rd_val;

    evt_regdec #(.NT(NT)) u_dec (
        .addr  (req_addr),
        .sel   (sel),
        .tsel  (tsel),
        .upper (upper)
    );

    // Write strobes and half-aligned write data.
    always_comb begin
        wr_ok     = req_valid && req_write;
        cfg_wr    = wr_ok && (sel == SEL_CFG) && !upper;
        cnt_wr_lo = wr_ok && (sel == SEL_CNT) && !upper;
        cnt_wr_hi = wr_ok && (sel == SEL_CNT) && (upper || req_wide);
        wd_al     = upper ? {req_wdata[31:0], 32'h0} : req_wdata;
        sts_clr   = (wr_ok && (sel == SEL_STS) && !upper) ? req_wdata[NT-1:0] : '0;
        sts_set   = tmr_hit & tmr_level;
    end

    // Configuration word: run and legacy bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= req_wdata[CFG_W-1:0];
    end

    evt_main_counter #(.W(64)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg_q[0]),
        .tick  (tick_en),
        .wr_lo (cnt_wr_lo),
        .wr_hi (cnt_wr_hi),
        .wdata (wd_al),
        .count (count)
    );

    evt_int_status #(.NT(NT)) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (sts_set),
        .clr_vec (sts_clr),
        .status  (status)
    );

    evt_irq_router #(.NT(NT), .RW(ROUTE_W)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_q[0]),
        .legacy (cfg_q[1]),
        .int_en (tmr_int_en),
        .level  (tmr_level),
        .hit    (tmr_hit),
        .route  (tmr_route),
        .status (status),
        .pit_in (pit_in),
        .rtc_in (rtc_in),
        .irq    (irq_line)
    );

    // Select the addressed register and the requested half.
    always_comb begin
        case (sel)
            SEL_CAP: rd_word = CAP_WORD;
            SEL_CFG: rd_word = {{(64-CFG_W){1'b0}}, cfg_q};
            SEL_STS: rd_word = {{(64-NT){1'b0}}, status};
            SEL_CNT: rd_word = count;
            SEL_TMR: rd_word = tmr_rdata;
            default: rd_word = '0;
        endcase
        if (sel == SEL_TMR) begin
            rd_val = rd_word;
        end else begin
            rd_val = upper ? {32'h0, rd_word[63:32]} : rd_word;
            if (!req_wide) rd_val[63:32] = 32'h0;
        end
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_data  <= (req_valid && !req_write) ? rd_val : '0;
        end
    end

    assign tmr_sel = req_valid ? tsel : '0;
    assign pit_en  = !cfg_q[1];

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_sel)); // R8
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write)); // R7
    AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && sel == SEL_CFG) |=> $stable(cfg_q)); // R3
endmodule

// File: tb/tb_evt_timer_global.sv
module tb_evt_timer_global;
    localparam int NTB = 4;
    localparam logic [63:0] CAP_EXP =
        {32'd10_000_000, 16'h5A17, 1'b1, 1'b0, 1'b1, 5'd3, 8'h01};

    logic clk = 0;
    logic rst_n = 0;
    logic tick_en = 0;
    logic req_valid = 0, req_write = 0, req_wide = 0;
    logic [9:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic rsp_valid;
    logic [63:0] rsp_data;
    logic [NTB-1:0] tmr_sel;
    logic [63:0] tmr_rdata;
    logic [NTB-1:0] tmr_hit = '0, tmr_level = '0, tmr_int_en = '0;
    logic [NTB*5-1:0] tmr_route = '0;
    logic pit_in = 0, rtc_in = 0;
    logic pit_en;
    logic [31:0] irq_line;

    // Clamp-check instances.
    logic rv_big, rv_small, pe_big, pe_small;
    logic [63:0] rd_big, rd_small;
    logic [31:0] sel_big, irq_big, irq_small;
    logic [2:0] sel_small;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign tmr_rdata = {32'hC0DE0000, 28'h0, tmr_sel};

    evt_timer_global #(.NUM_TIMERS(NTB)) dut (
        .clk, .rst_n, .tick_en, .req_valid, .req_write, .req_wide, .req_addr,
        .req_wdata, .rsp_valid, .rsp_data, .tmr_sel, .tmr_rdata, .tmr_hit,
        .tmr_level, .tmr_int_en, .tmr_route, .pit_in, .rtc_in, .pit_en, .irq_line
    );

    evt_timer_global #(.NUM_TIMERS(40)) dut_big (
        .clk, .rst_n, .tick_en, .req_valid, .req_write, .req_wide, .req_addr,
        .req_wdata, .rsp_valid(rv_big), .rsp_data(rd_big), .tmr_sel(sel_big),
        .tmr_rdata(64'h0), .tmr_hit(32'h0), .tmr_level(32'h0), .tmr_int_en(32'h0),
        .tmr_route(160'h0), .pit_in(1'b0), .rtc_in(1'b0), .pit_en(pe_big), .irq_line(irq_big)
    );

    evt_timer_global #(.NUM_TIMERS(1)) dut_small (
        .clk, .rst_n, .tick_en, .req_valid, .req_write, .req_wide, .req_addr,
        .req_wdata, .rsp_valid(rv_small), .rsp_data(rd_small), .tmr_sel(sel_small),
        .tmr_rdata(64'h0), .tmr_hit(3'h0), .tmr_level(3'h0), .tmr_int_en(3'h0),
        .tmr_route(15'h0), .pit_in(1'b0), .rtc_in(1'b0), .pit_en(pe_small), .irq_line(irq_small)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [63:0] d, input logic wide);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_wide = wide;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic bus_read(input logic [9:0] a, input logic wide, output logic [63:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_wide = wide;
        @(negedge clk);
        d = rsp_data;
        req_valid = 0;
    endtask

    task automatic hit_pulse(input logic [NTB-1:0] v);
        @(negedge clk);
        tmr_hit = v;
        @(negedge clk);
        tmr_hit = '0;
    endtask

    function automatic logic [63:0] exp_read(input int a, input logic wide);
        logic [63:0] w;
        int idx;
        if (a >= 'h100) begin
            idx = (a - 'h100) / 32;
            if (idx < NTB) return {32'hC0DE0000, 28'h0, 4'(1 << idx)};
            return 64'h0;
        end
        case (a & ~7)
            'h000:   w = CAP_EXP;
            default: w = 64'h0;
        endcase
        w = (a & 4) ? {32'h0, w[63:32]} : w;
        if (!wide) w[63:32] = 32'h0;
        return w;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        bus_read(10'h010, 1, d); check("R1 cfg", d, 0);
        bus_read(10'h0F0, 1, d); check("R1 counter", d, 0);
        bus_read(10'h020, 1, d); check("R1 status", d, 0);
        check("R1 pit_en", {63'h0, pit_en}, 1);
        check("R1 irq", {32'h0, irq_line}, 0);

        // R7 R8 R2: sweep every address at both widths
        for (int a = 0; a < 1024; a += 4) begin
            bus_read(a[9:0], 0, d);
            check($sformatf("R8 R7 rd32 %0h", a), d, exp_read(a, 0));
        end
        for (int a = 0; a < 1024; a += 8) begin
            bus_read(a[9:0], 1, d);
            check($sformatf("R8 R7 rd64 %0h", a), d, exp_read(a, 1));
        end

        // R2: capability is read-only
        bus_write(10'h000, 64'hFFFF_FFFF_FFFF_FFFF, 1);
        bus_write(10'h004, 64'h0, 0);
        bus_read(10'h000, 1, d); check("R2 cap after write", d, CAP_EXP);

        // R3: only bits 1:0 writable; upper half has no effect
        bus_write(10'h010, 64'hFFFF_FFFF_FFFF_FFFC, 1);
        bus_read(10'h010, 1, d); check("R3 reserved bits", d, 0);
        bus_write(10'h014, 64'h3, 0);
        bus_read(10'h010, 1, d); check("R3 upper half", d, 0);

        // R5 R4: load while halted, ticks ignored while halted
        bus_write(10'h0F0, 64'h0000_0001_FFFF_FFFE, 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); tick_en = 1; @(negedge clk); tick_en = 0;
        end
        bus_read(10'h0F0, 1, d); check("R4 frozen", d, 64'h0000_0001_FFFF_FFFE);
        bus_write(10'h010, 64'h1, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tick_en = 1; @(negedge clk); tick_en = 0;
        end
        bus_write(10'h010, 64'h0, 0);
        bus_read(10'h0F0, 1, d); check("R4 three ticks", d, 64'h0000_0002_0000_0001);
        bus_read(10'h0F4, 0, d); check("R7 upper half", d, 64'h2);
        bus_read(10'h0F0, 0, d); check("R7 lower half", d, 64'h1);

        // R5: write while running beats a simultaneous tick
        bus_write(10'h010, 64'h1, 0);
        @(negedge clk);
        tick_en = 1;
        req_valid = 1; req_write = 1; req_addr = 10'h0F0; req_wdata = 64'h100; req_wide = 0;
        @(negedge clk);
        req_addr = 10'h010; req_wdata = 64'h0;
        @(negedge clk);
        req_valid = 0; req_write = 0; tick_en = 0;
        bus_read(10'h0F0, 1, d); check("R5 load over tick", d, 64'h0000_0002_0000_0101);
        bus_write(10'h0F4, 64'h7, 0);
        bus_read(10'h0F0, 1, d); check("R5 upper load", d, 64'h0000_0007_0000_0101);

        // R6: pending word
        tmr_level = 4'b0111;
        hit_pulse(4'b1111);
        bus_read(10'h020, 1, d); check("R6 set level only", d, 64'h7);
        bus_write(10'h020, 64'h0, 0);
        bus_read(10'h020, 1, d); check("R6 zero write", d, 64'h7);
        bus_write(10'h020, 64'h2, 0);
        bus_read(10'h020, 1, d); check("R6 clear bit1", d, 64'h5);
        bus_write(10'h024, 64'hF, 0);
        bus_read(10'h020, 1, d); check("R6 upper write", d, 64'h5);
        @(negedge clk);
        tmr_hit = 4'b0001;
        req_valid = 1; req_write = 1; req_addr = 10'h020; req_wdata = 64'h1; req_wide = 0;
        @(negedge clk);
        tmr_hit = '0; req_valid = 0; req_write = 0;
        bus_read(10'h020, 1, d); check("R6 set beats clear", d, 64'h5);
        bus_write(10'h020, 64'h5, 0);
        bus_read(10'h020, 1, d); check("R6 cleared", d, 64'h0);

        // R9: routing and timing, run on, not legacy
        tmr_route = {5'd9, 5'd8, 5'd5, 5'd3};
        tmr_int_en = 4'b1111;
        bus_write(10'h010, 64'h1, 0);
        @(negedge clk);
        check("R9 idle", {32'h0, irq_line}, 0);
        hit_pulse(4'b0001);
        check("R9 not yet", {32'h0, irq_line}, 0);
        @(negedge clk);
        check("R9 level line", {32'h0, irq_line}, 32'h8);
        hit_pulse(4'b1000);
        @(negedge clk);
        check("R9 edge pulse", {32'h0, irq_line}, 32'h208);
        @(negedge clk);
        check("R9 edge one cycle", {32'h0, irq_line}, 32'h8);
        bus_read(10'h020, 1, d); check("R9 edge no pending", d, 64'h1);
        tmr_int_en = 4'b1110;
        @(negedge clk);
        check("R9 int disabled", {32'h0, irq_line}, 0);
        tmr_int_en = 4'b1111;
        @(negedge clk);
        check("R9 int re-enabled", {32'h0, irq_line}, 32'h8);

        // R12: run off drops lines, keeps pending; run on re-asserts
        bus_write(10'h010, 64'h0, 0);
        @(negedge clk);
        check("R12 run off", {32'h0, irq_line}, 0);
        bus_read(10'h020, 1, d); check("R12 pending kept", d, 64'h1);
        bus_write(10'h010, 64'h1, 0);
        check("R12 not yet", {32'h0, irq_line}, 0);
        @(negedge clk);
        check("R12 re-asserted", {32'h0, irq_line}, 32'h8);

        // R10 R11: legacy replacement
        bus_write(10'h010, 64'h3, 0);
        check("R11 pit_en low", {63'h0, pit_en}, 0);
        @(negedge clk);
        check("R10 t0 to line0", {32'h0, irq_line}, 32'h1);
        pit_in = 1; rtc_in = 1;
        @(negedge clk);
        @(negedge clk);
        check("R11 gated", {32'h0, irq_line}, 32'h1);
        hit_pulse(4'b0010);
        @(negedge clk);
        check("R10 t1 to line8", {32'h0, irq_line}, 32'h101);
        bus_write(10'h020, 64'hF, 0);
        @(negedge clk);
        check("R10 cleared", {32'h0, irq_line}, 0);
        hit_pulse(4'b0100);
        @(negedge clk);
        check("R10 t2 keeps route", {32'h0, irq_line}, 32'h100);
        bus_write(10'h020, 64'h4, 0);
        @(negedge clk);
        check("R10 t2 cleared", {32'h0, irq_line}, 0);
        bus_write(10'h010, 64'h1, 0);
        check("R11 pit_en back", {63'h0, pit_en}, 1);
        @(negedge clk);
        check("R11 pass-through", {32'h0, irq_line}, 32'h101);
        pit_in = 0;
        @(negedge clk);
        @(negedge clk);
        check("R11 rtc follows", {32'h0, irq_line}, 32'h100);
        rtc_in = 0;

        // R13: channel-count clamp
        bus_read(10'h000, 1, d);
        check("R13 nominal", {59'h0, d[12:8]}, 3);
        check("R13 clamp high", {59'h0, rd_big[12:8]}, 31);
        check("R13 clamp low", {59'h0, rd_small[12:8]}, 2);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule